// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol engine of a two-wire serial memory slave. It watches the clock and data lines, which arrive as samples already synchronised to the system clock. It recognises START and STOP conditions and decodes the device-select byte against three chip-enable pins. It then collects a two-byte memory address, accepts data bytes to write, or streams stored bytes back to the bus master. Its only bus output is a registered pull-down enable for the open-drain data line.

Writes are not stored here. Each accepted data byte appears as a one-cycle strobe to an external page latch, together with its address. A STOP that arrives in the slot straight after a data-byte acknowledge raises a one-cycle commit strobe for the program-cycle controller. While that controller reports busy, the engine stays silent on the bus, so a master can poll for completion. Reads come from a memory port with one cycle of read latency, addressed by an internal address counter.

Top module: `twi_eeprom_engine`

## Requirements
- R1: A START is a falling data line while the clock line is high. A STOP is a rising data line while the clock line is high. A STOP always releases the data line and returns the engine to standby.
- R2: The first byte after a START is received MSB first. Bits 7..4 must equal 1010 and bits 3..1 must equal `chip_en_i[2:0]`; bit 0 is the direction, where 1 means read. On any mismatch the engine does not acknowledge, leaves the data line released, and waits for the next START.
- R3: A write-direction select is followed by an upper and then a lower address byte. Bits of the upper byte above the counter width are ignored. The select and both address bytes are each acknowledged by a low data line during the ninth clock.
- R4: Each acknowledged data byte produces one `mem_wr_o` strobe, carrying the byte and the counter address. `prog_start_o` pulses only for a STOP that follows the first clock pulse after an acknowledged data byte; a STOP at any other point commits nothing.
- R5: After each written byte, only the low `PAGE_W` bits of the address counter advance, so a page write wraps within its page.
- R6: If `wr_ctrl_i` is high at any time from the START to the end of the lower address byte, the select and address bytes are still acknowledged. Every data byte is then left unacknowledged, and no write strobe and no commit occur.
- R7: A read-direction select outputs the byte at the counter address, MSB first, and the counter then advances over its full width, wrapping at the top. A random read is a write-direction select with two address bytes, followed by a repeated START and a read-direction select.
- R8: A master acknowledge in the ninth slot of a read byte makes the engine send the next byte. No acknowledge makes it release the line and enter standby.
- R9: While `busy_i` is high the engine ignores the bus: it acknowledges nothing and never pulls the data line low.
- R10: The engine starts pulling the data line low only while the clock line is low.
- R11: A START seen in any state, including part-way through a byte, restarts reception of a device-select byte.
- R12: After reset the data line is released and no write or commit strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised serial clock line sample |
| sda_i | input | 1 | Synchronised serial data line sample (wired bus value) |
| chip_en_i | input | 3 | Chip-enable pins compared against select bits 3..1 |
| wr_ctrl_i | input | 1 | Write-control; high blocks data writes |
| busy_i | input | 1 | Program cycle in progress |
| sda_pull_o | output | 1 | Pull-down enable for the open-drain data line |
| mem_rd_addr_o | output | ADDR_W | Read address (address counter value) |
| mem_rd_data_i | input | 8 | Read data, valid one cycle after the address |
| mem_wr_o | output | 1 | One-cycle strobe per accepted data byte |
| mem_wr_addr_o | output | ADDR_W | Address of the accepted data byte |
| mem_wr_data_o | output | 8 | Accepted data byte |
| prog_start_o | output | 1 | One-cycle strobe that starts the program cycle |

## Verification
The hardest case to reach from the ports is telling a STOP in the tenth-bit slot apart from a STOP anywhere else. The bench therefore sends one acknowledged data byte followed by a few stray bits and then a STOP. It checks that neither the busy window nor the stored byte changes. Polling during the program cycle is reached by issuing select bytes straight after a committing STOP, while the bench's own program-cycle model is still busy. The polls are repeated until an acknowledge returns, and the written byte is then read back.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK
  } phase_t;

  typedef enum logic [1:0] {
    BK_SEL,
    BK_AHI,
    BK_ALO,
    BK_DATA
  } kind_t;

  localparam logic [3:0] TYPE_CODE = 4'b1010;

endpackage

// File: rtl/twi_line_events.sv
module twi_line_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_page_i,
  input  logic              inc_all_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] page_next;

  generate
    if (PAGE_W >= ADDR_W) begin : g_flat
      assign page_next = addr_o + 1'b1;
    end else begin : g_split
      logic [PAGE_W-1:0] low_next;
      assign low_next  = addr_o[PAGE_W-1:0] + 1'b1;
      assign page_next = {addr_o[ADDR_W-1:PAGE_W], low_next};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
    end else if (load_i) begin
      addr_o <= load_val_i;
    end else if (inc_page_i) begin
      addr_o <= page_next;
    end else if (inc_all_i) begin
      addr_o <= addr_o + 1'b1;
    end
  end

endmodule

// File: rtl/twi_eeprom_engine.sv
module twi_eeprom_engine
  import twi_eeprom_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        chip_en_i,
  input  logic              wr_ctrl_i,
  input  logic              busy_i,
  output logic              sda_pull_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic [7:0]        mem_rd_data_i,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [7:0]        mem_wr_data_o,
  output logic              prog_start_o
);

  localparam int HI_W = ADDR_W - 8;

  logic ev_rise;
  logic ev_fall;
  logic ev_start;
  logic ev_stop;

  phase_t            phase_q;
  kind_t             kind_q;
  kind_t             next_kind_q;
  logic [3:0]        bitcnt_q;
  logic [7:0]        shreg_q;
  logic              go_tx_q;
  logic              wp_q;
  logic              pend_q;
  logic              mack_q;
  logic [HI_W-1:0]   hi_q;
  logic              ctr_load_q;
  logic              ctr_inc_page_q;
  logic              ctr_inc_all_q;
  logic [ADDR_W-1:0] ctr_val_q;
  logic [ADDR_W-1:0] addr_w;
  logic              sel_match;
  logic              wp_now;

  twi_line_events u_events (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (ev_rise),
    .scl_fall_o (ev_fall),
    .start_o    (ev_start),
    .stop_o     (ev_stop)
  );

  twi_addr_ctr #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (ctr_load_q),
    .load_val_i (ctr_val_q),
    .inc_page_i (ctr_inc_page_q),
    .inc_all_i  (ctr_inc_all_q),
    .addr_o     (addr_w)
  );

  assign mem_rd_addr_o = addr_w;
  assign sel_match = (shreg_q[7:4] == TYPE_CODE) && (shreg_q[3:1] == chip_en_i);
  // protection window closes once the lower address byte has been taken
  assign wp_now = wp_q | ((kind_q != BK_DATA) & wr_ctrl_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q        <= PH_IDLE;
      kind_q         <= BK_SEL;
      next_kind_q    <= BK_SEL;
      bitcnt_q       <= '0;
      shreg_q        <= '0;
      go_tx_q        <= 1'b0;
      wp_q           <= 1'b0;
      pend_q         <= 1'b0;
      mack_q         <= 1'b0;
      hi_q           <= '0;
      ctr_load_q     <= 1'b0;
      ctr_inc_page_q <= 1'b0;
      ctr_inc_all_q  <= 1'b0;
      ctr_val_q      <= '0;
      sda_pull_o     <= 1'b0;
      mem_wr_o       <= 1'b0;
      mem_wr_addr_o  <= '0;
      mem_wr_data_o  <= '0;
      prog_start_o   <= 1'b0;
    end else begin
      mem_wr_o       <= 1'b0;
      prog_start_o   <= 1'b0;
      ctr_load_q     <= 1'b0;
      ctr_inc_page_q <= 1'b0;
      ctr_inc_all_q  <= 1'b0;

      if (busy_i) begin
        phase_q    <= PH_IDLE;
        sda_pull_o <= 1'b0;
      end else if (ev_start) begin
        phase_q    <= PH_RX;
        kind_q     <= BK_SEL;
        bitcnt_q   <= '0;
        sda_pull_o <= 1'b0;
        wp_q       <= wr_ctrl_i;
        pend_q     <= 1'b0;
      end else if (ev_stop) begin
        // commit only in the slot right after a data acknowledge
        if (phase_q == PH_RX && kind_q == BK_DATA && bitcnt_q == 4'd1 && pend_q) begin
          prog_start_o <= 1'b1;
        end
        phase_q    <= PH_IDLE;
        pend_q     <= 1'b0;
        sda_pull_o <= 1'b0;
      end else begin
        case (phase_q)
          PH_RX: begin
            wp_q <= wp_now;
            if (ev_rise) begin
              shreg_q  <= {shreg_q[6:0], sda_i};
              bitcnt_q <= bitcnt_q + 4'd1;
            end else if (ev_fall && bitcnt_q == 4'd8) begin
              bitcnt_q <= '0;
              phase_q  <= PH_RX_ACK;
              go_tx_q  <= 1'b0;
              case (kind_q)
                BK_SEL: begin
                  if (sel_match) begin
                    sda_pull_o  <= 1'b1;
                    go_tx_q     <= shreg_q[0];
                    next_kind_q <= BK_AHI;
                  end else begin
                    phase_q <= PH_IDLE;
                  end
                end
                BK_AHI: begin
                  hi_q        <= shreg_q[HI_W-1:0];
                  sda_pull_o  <= 1'b1;
                  next_kind_q <= BK_ALO;
                end
                BK_ALO: begin
                  ctr_val_q   <= {hi_q, shreg_q};
                  ctr_load_q  <= 1'b1;
                  sda_pull_o  <= 1'b1;
                  next_kind_q <= BK_DATA;
                end
                default: begin
                  next_kind_q <= BK_DATA;
                  if (!wp_now) begin
                    sda_pull_o     <= 1'b1;
                    mem_wr_o       <= 1'b1;
                    mem_wr_addr_o  <= addr_w;
                    mem_wr_data_o  <= shreg_q;
                    ctr_inc_page_q <= 1'b1;
                    pend_q         <= 1'b1;
                  end
                end
              endcase
            end
          end

          PH_RX_ACK: begin
            if (ev_fall) begin
              if (go_tx_q) begin
                shreg_q       <= mem_rd_data_i;
                sda_pull_o    <= ~mem_rd_data_i[7];
                ctr_inc_all_q <= 1'b1;
                bitcnt_q      <= '0;
                phase_q       <= PH_TX;
              end else begin
                sda_pull_o <= 1'b0;
                kind_q     <= next_kind_q;
                phase_q    <= PH_RX;
              end
            end
          end

          PH_TX: begin
            if (ev_fall) begin
              if (bitcnt_q == 4'd7) begin
                sda_pull_o <= 1'b0;
                phase_q    <= PH_TX_ACK;
              end else begin
                shreg_q    <= {shreg_q[6:0], 1'b0};
                sda_pull_o <= ~shreg_q[6];
                bitcnt_q   <= bitcnt_q + 4'd1;
              end
            end
          end

          PH_TX_ACK: begin
            if (ev_rise) begin
              mack_q <= ~sda_i;
            end else if (ev_fall) begin
              if (mack_q) begin
                shreg_q       <= mem_rd_data_i;
                sda_pull_o    <= ~mem_rd_data_i[7];
                ctr_inc_all_q <= 1'b1;
                bitcnt_q      <= '0;
                phase_q       <= PH_TX;
              end else begin
                sda_pull_o <= 1'b0;
                phase_q    <= PH_IDLE;
              end
            end
          end

          default: begin
            sda_pull_o <= 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/twi_eeprom_chk.sv
module twi_eeprom_chk (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic busy_i,
  input logic sda_pull_o,
  input logic mem_wr_o,
  input logic prog_start_o,
  input logic stop_det
);

  // R9: a busy program cycle keeps the line released
  p_quiet_when_busy_r9: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> !sda_pull_o);

  // R10: pull-down only begins after the clock line has gone low
  p_drive_on_low_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> !$past(scl_i));

  // R1: a STOP returns the line to released
  p_stop_release_r1: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_pull_o);

  // R4: a byte strobe and a commit never coincide
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_wr_o, prog_start_o}));

endmodule

bind twi_eeprom_engine twi_eeprom_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .scl_i        (scl_i),
  .busy_i       (busy_i),
  .sda_pull_o   (sda_pull_o),
  .mem_wr_o     (mem_wr_o),
  .prog_start_o (prog_start_o),
  .stop_det     (ev_stop)
);

// File: tb/twi_eeprom_engine_tb_top.sv
`timescale 1ns/1ps
module twi_eeprom_engine_tb_top;

  localparam int AW    = 10;
  localparam int PW    = 5;
  localparam int DEPTH = 1 << AW;
  localparam logic [7:0] SEL_W  = 8'hAA;
  localparam logic [7:0] SEL_R  = 8'hAB;
  localparam logic [7:0] BAD_CE = 8'hA8;
  localparam logic [7:0] BAD_TY = 8'hBA;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          scl_r = 1'b1;
  logic          m_low = 1'b0;
  logic          wc = 1'b0;
  logic          busy;
  logic          sda_line;
  logic          pull;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          wr_stb;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          commit;

  logic [7:0] store   [0:DEPTH-1];
  logic [7:0] exp_mem [0:DEPTH-1];
  logic [7:0] latch_d [0:DEPTH-1];
  logic       latch_v [0:DEPTH-1];
  int         busy_cnt = 0;

  int checks = 0;
  int fails  = 0;
  int viol   = 0;
  bit done   = 0;
  logic prev_pull = 1'b0;
  logic prev_scl  = 1'b1;

  always #2 clk = ~clk;

  assign sda_line = ~(m_low | pull);
  assign busy     = (busy_cnt != 0);

  twi_eeprom_engine #(.ADDR_W(AW), .PAGE_W(PW)) dut_i (
    .clk           (clk),
    .rst           (rst),
    .scl_i         (scl_r),
    .sda_i         (sda_line),
    .chip_en_i     (3'b101),
    .wr_ctrl_i     (wc),
    .busy_i        (busy),
    .sda_pull_o    (pull),
    .mem_rd_addr_o (rd_addr),
    .mem_rd_data_i (rd_data),
    .mem_wr_o      (wr_stb),
    .mem_wr_addr_o (wr_addr),
    .mem_wr_data_o (wr_data),
    .prog_start_o  (commit)
  );

  function automatic logic [7:0] seed(int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      store[i]   = seed(i);
      exp_mem[i] = seed(i);
      latch_v[i] = 1'b0;
      latch_d[i] = 8'h00;
    end
  end

  // memory, page latch and program-cycle model
  always @(posedge clk) begin
    rd_data <= store[rd_addr];
    if (wr_stb) begin
      latch_d[wr_addr] <= wr_data;
      latch_v[wr_addr] <= 1'b1;
    end
    if (commit) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (latch_v[i]) store[i] <= latch_d[i];
        latch_v[i] <= 1'b0;
      end
      busy_cnt <= 200;
    end else if (busy_cnt != 0) begin
      busy_cnt <= busy_cnt - 1;
    end
  end

  // R10 monitor: a new pull-down must not begin while the clock is high
  always @(negedge clk) begin
    #1;
    if (!rst && !prev_pull && pull && prev_scl) viol++;
    prev_pull = pull;
    prev_scl  = scl_r;
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(bit b);
    m_low = ~b; tick(3);
    scl_r = 1'b1; tick(6);
    scl_r = 1'b0; tick(3);
  endtask

  task automatic get_ack(output bit ack);
    m_low = 1'b0; tick(3);
    scl_r = 1'b1; tick(3);
    ack = ~sda_line; tick(3);
    scl_r = 1'b0; tick(3);
  endtask

  task automatic send_byte(logic [7:0] v, output bit ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_ack(ack);
  endtask

  task automatic recv_byte(bit give_ack, output logic [7:0] v);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(3); scl_r = 1'b1;
      tick(3); v[i] = sda_line;
      tick(3); scl_r = 1'b0;
      tick(3);
    end
    m_low = give_ack; tick(3);
    scl_r = 1'b1; tick(6);
    scl_r = 1'b0; tick(1);
    m_low = 1'b0; tick(2);
  endtask

  task automatic do_start();
    m_low = 1'b0; tick(3);
    scl_r = 1'b1; tick(3);
    m_low = 1'b1; tick(3);
    scl_r = 1'b0; tick(3);
  endtask

  task automatic do_stop();
    m_low = 1'b1; tick(3);
    scl_r = 1'b1; tick(3);
    m_low = 1'b0; tick(6);
  endtask

  task automatic set_addr(int a, output bit a1, output bit a2, output bit a3);
    do_start();
    send_byte(SEL_W, a1);
    send_byte(8'hE0 | 8'(a >> 8), a2);
    send_byte(8'(a), a3);
  endtask

  task automatic wait_free();
    while (busy) tick(1);
    tick(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit a1, a2, a3, a4;
    logic [7:0] v;
    int polls;

    tick(5);
    rst = 1'b0;
    tick(2);
    // R12 reset state
    check(pull == 1'b0 && wr_stb == 1'b0 && commit == 1'b0, "R12", int'(pull), 0);

    // R2 mismatching chip enable and type code
    do_start();
    send_byte(BAD_CE, a1);
    check(!a1, "R2 chip enable", int'(a1), 0);
    do_start();
    send_byte(BAD_TY, a1);
    check(!a1, "R2 type code", int'(a1), 0);
    do_stop();
    check(pull == 1'b0, "R1 release after STOP", int'(pull), 0);

    // R3 / R7 random read
    set_addr(341, a1, a2, a3);
    check(a1 && a2 && a3, "R3 select and address acks", int'({a1, a2, a3}), 7);
    do_start();
    send_byte(SEL_R, a4);
    check(a4, "R7 read select ack", int'(a4), 1);
    recv_byte(1'b0, v);
    check(v == exp_mem[341], "R7 random read", int'(v), int'(exp_mem[341]));
    do_stop();

    // R7 current address read
    do_start();
    send_byte(SEL_R, a4);
    recv_byte(1'b0, v);
    check(v == exp_mem[342], "R7 current read", int'(v), int'(exp_mem[342]));
    do_stop();

    // R8 sequential read across top of memory
    set_addr(DEPTH - 2, a1, a2, a3);
    do_start();
    send_byte(SEL_R, a4);
    for (int k = 0; k < 4; k++) begin
      int ea;
      ea = (DEPTH - 2 + k) % DEPTH;
      recv_byte(k != 3, v);
      check(v == exp_mem[ea], "R8 sequential", int'(v), int'(exp_mem[ea]));
    end
    check(pull == 1'b0, "R8 release after no-ack", int'(pull), 0);
    do_stop();
    do_start();
    send_byte(SEL_R, a4);
    recv_byte(1'b0, v);
    check(v == exp_mem[2], "R7 counter wrap", int'(v), int'(exp_mem[2]));
    do_stop();

    // R4 byte write, R9 polling
    set_addr(100, a1, a2, a3);
    send_byte(8'h5A, a4);
    check(a4, "R4 data ack", int'(a4), 1);
    do_stop();
    exp_mem[100] = 8'h5A;
    check(busy == 1'b1, "R4 commit after STOP", int'(busy), 1);
    polls = 0;
    a1 = 1'b0;
    while (!a1 && polls < 50) begin
      do_start();
      send_byte(SEL_W, a1);
      if (!a1) begin
        check(pull == 1'b0, "R9 line released", int'(pull), 0);
        do_stop();
        polls++;
      end
    end
    check(polls >= 1 && a1, "R9 busy poll", polls, 1);
    send_byte(8'h00, a2);
    send_byte(8'd100, a3);
    do_start();
    send_byte(SEL_R, a4);
    recv_byte(1'b0, v);
    check(v == 8'h5A, "R4 byte write readback", int'(v), 8'h5A);
    do_stop();

    // R5 page write wrapping inside its page
    set_addr(126, a1, a2, a3);
    for (int k = 0; k < 4; k++) begin
      int ea;
      ea = 96 + ((30 + k) % 32);
      send_byte(8'(8'hC0 + k), a4);
      exp_mem[ea] = 8'(8'hC0 + k);
    end
    do_stop();
    wait_free();
    set_addr(126, a1, a2, a3);
    do_start();
    send_byte(SEL_R, a4);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k != 2, v);
      check(v == exp_mem[126 + k], "R5 page end", int'(v), int'(exp_mem[126 + k]));
    end
    do_stop();
    set_addr(96, a1, a2, a3);
    do_start();
    send_byte(SEL_R, a4);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k != 2, v);
      check(v == exp_mem[96 + k], "R5 page wrap", int'(v), int'(exp_mem[96 + k]));
    end
    do_stop();

    // R6 write-control high only during the lower address byte
    do_start();
    send_byte(SEL_W, a1);
    send_byte(8'h00, a2);
    wc = 1'b1;
    send_byte(8'd50, a3);
    wc = 1'b0;
    check(a1 && a2 && a3, "R6 select/address acked", int'({a1, a2, a3}), 7);
    send_byte(8'h77, a4);
    check(!a4, "R6 data not acked", int'(a4), 0);
    send_byte(8'h78, a4);
    check(!a4, "R6 second data not acked", int'(a4), 0);
    do_stop();
    check(busy == 1'b0, "R6 no commit", int'(busy), 0);
    set_addr(50, a1, a2, a3);
    do_start();
    send_byte(SEL_R, a4);
    recv_byte(1'b0, v);
    check(v == exp_mem[50], "R6 memory unchanged", int'(v), int'(exp_mem[50]));
    do_stop();

    // R4 STOP outside the tenth-bit slot commits nothing
    set_addr(200, a1, a2, a3);
    send_byte(8'h33, a4);
    put_bit(1'b1);
    put_bit(1'b0);
    put_bit(1'b1);
    do_stop();
    check(busy == 1'b0, "R4 late STOP no commit", int'(busy), 0);
    set_addr(200, a1, a2, a3);
    do_start();
    send_byte(SEL_R, a4);
    recv_byte(1'b0, v);
    check(v == exp_mem[200], "R4 late STOP memory", int'(v), int'(exp_mem[200]));
    do_stop();

    // R11 START in the middle of a byte
    do_start();
    put_bit(1'b1);
    put_bit(1'b1);
    put_bit(1'b0);
    put_bit(1'b1);
    set_addr(777, a1, a2, a3);
    check(a1 && a2 && a3, "R11 restart acks", int'({a1, a2, a3}), 7);
    do_start();
    send_byte(SEL_R, a4);
    recv_byte(1'b0, v);
    check(v == exp_mem[777], "R11 restart read", int'(v), int'(exp_mem[777]));
    do_stop();

    // R10 monitor result
    check(viol == 0, "R10 pull begins on low clock", viol, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule